// File: doc/BRIEF.md
# Descriptor Image Header Checker

This block watches a byte stream that carries a device descriptor image, starting at its first byte, and decides whether the image header is sound. While the bytes arrive, it picks out the header fields and runs two checksums, one byte per clock. It then compares the declared image size with the number of bytes it actually received.

One clock after the final byte, the block raises a one-cycle completion strobe together with a status bundle. The bundle holds a pass flag, an error code, the 64-bit unique identifier, the computed image size and a revision warning. The producer of the stream marks the final byte with an end flag. It may leave idle cycles between bytes, and the next accepted byte opens a new image.

Top module: `desc_hdr_check`

## Requirements
- R1: A byte is taken only in a cycle where `in_valid` is high; `in_data` and `in_last` are ignored otherwise. The first byte taken after reset, or after a byte taken with `in_last` high, is image byte 0.
- R2: The header layout is as follows, with multi-byte fields little-endian. Byte 0 is the identifier checksum. Bytes 1..8 form `uid`, with byte 1 least significant. Bytes 9..12 hold the data checksum. Byte 13 is the revision. The length is byte 14 plus bits 1:0 of byte 15 as bits 9:8. The upper six bits of byte 15 are ignored, and `img_size` equals length + 13.
- R3: If `img_size` is below 22, the error code is 1 (too small).
- R4: If fewer than 16 bytes were received, or the received count differs from `img_size`, the error code is 2 (size mismatch).
- R5: The identifier checksum is a CRC-8 over bytes 1..8 with polynomial 0x07, start value 0xFF, most significant bit first and no output inversion. If it differs from byte 0, the error code is 3.
- R6: The data checksum is a CRC-32C over `length` bytes starting at byte 13. It uses reflected polynomial 0x82F63B78, start value all ones and final inversion. If it differs from bytes 9..12, the error code is 4. With no failure, the code is 0.
- R7: When several failures apply, the reported code follows the priority 2 for a stream of under 16 bytes, then 1, then 2, then 3, then 4.
- R8: `rev_warn` is high when the revision byte is greater than 1. It has no effect on `pass` or `err_code`.
- R9: `done` is high for exactly one cycle, the cycle after the clock edge that takes the final byte. In that cycle `pass` is high exactly when `err_code` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Byte present on `in_data` |
| in_data | input | 8 | Image byte |
| in_last | input | 1 | Marks the final byte of the image |
| done | output | 1 | One-cycle strobe: status valid |
| pass | output | 1 | Header accepted |
| err_code | output | 3 | 0 none, 1 too small, 2 size mismatch, 3 identifier CRC, 4 data CRC |
| uid | output | 64 | Unique identifier from bytes 1..8 |
| rev_warn | output | 1 | Revision above 1 |
| img_size | output | 11 | Declared length + 13 |

## Verification
The hardest situations to reach are those where several failures overlap, because only one code can be reported. Examples are an undersized image that also carries a wrong identifier CRC, or an image that is one byte too long or too short while its checksums still match the declared region. The stimulus builds consistent images with correct CRCs and then corrupts one or two chosen bytes or changes the byte count. It also places idle cycles between bytes and drives random `in_data` and `in_last` values during those cycles. A maximum-length image and the exact 22-byte boundary are driven as directed cases.

// File: rtl/desc_hdr_pkg.sv
package desc_hdr_pkg;

  typedef enum logic [2:0] {
    ERR_NONE    = 3'd0,
    ERR_SMALL   = 3'd1,
    ERR_SIZE    = 3'd2,
    ERR_IDCRC   = 3'd3,
    ERR_DATACRC = 3'd4
  } hdr_err_e;

  // Byte positions the checker decodes
  localparam int unsigned OFS_UID    = 1;
  localparam int unsigned UID_BYTES  = 8;
  localparam int unsigned OFS_DCRC   = 9;
  localparam int unsigned DCRC_BYTES = 4;
  localparam int unsigned OFS_REV    = 13;
  localparam int unsigned OFS_LEN    = 14;
  localparam int unsigned DATA_START = 13;
  localparam int unsigned LEN_SEEN   = 16;
  localparam int unsigned HDR_BYTES  = 22;

endpackage

// File: rtl/crc_lane.sv
module crc_lane #(
  parameter int            W         = 8,
  parameter logic [W-1:0]  POLY      = '0,
  parameter logic [W-1:0]  INIT      = '1,
  parameter bit            LSB_FIRST = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic [7:0]   din,
  output logic [W-1:0] crc_q
);

  logic [W-1:0] step;
  logic [W-1:0] crc_d;

  generate
    if (LSB_FIRST) begin : g_reflected
      always_comb begin
        step = crc_q ^ W'(din);
        for (int k = 0; k < 8; k++) begin
          step = step[0] ? ((step >> 1) ^ POLY) : (step >> 1);
        end
      end
    end else begin : g_normal
      always_comb begin
        step = crc_q ^ (W'(din) << (W - 8));
        for (int k = 0; k < 8; k++) begin
          step = step[W-1] ? ((step << 1) ^ POLY) : (step << 1);
        end
      end
    end
  endgenerate

  always_comb begin
    crc_d = crc_q;
    if (clr)     crc_d = INIT;
    else if (en) crc_d = step;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         crc_q <= INIT;
    else if (clr || en) crc_q <= crc_d;
  end

  // R1: an idle lane keeps its value
  p_idle_holds_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !en) |=> $stable(crc_q));

  // R5: every image starts from the start value
  p_clear_init_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (crc_q == INIT));

endmodule

// File: rtl/hdr_fields.sv
module hdr_fields
  import desc_hdr_pkg::*;
#(
  parameter int LEN_W = 10,
  parameter int CNT_W = LEN_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc,
  input  logic [CNT_W-1:0] idx,
  input  logic [7:0]       din,
  output logic [7:0]       id_exp,
  output logic [63:0]      uid,
  output logic [31:0]      dcrc_exp,
  output logic [7:0]       rev,
  output logic [LEN_W-1:0] dlen
);

  localparam logic [CNT_W-1:0] C_REV    = CNT_W'(OFS_REV);
  localparam logic [CNT_W-1:0] C_LEN_LO = CNT_W'(OFS_LEN);
  localparam logic [CNT_W-1:0] C_LEN_HI = CNT_W'(OFS_LEN + 1);

  logic             start;
  logic [7:0]       id_d;
  logic [63:0]      uid_d;
  logic [31:0]      dcrc_d;
  logic [7:0]       rev_d;
  logic [LEN_W-1:0] dlen_d;

  assign start = acc && (idx == '0);

  always_comb begin
    id_d   = id_exp;
    uid_d  = uid;
    dcrc_d = dcrc_exp;
    rev_d  = rev;
    dlen_d = dlen;
    if (start) begin
      id_d   = din;
      uid_d  = '0;
      dcrc_d = '0;
      rev_d  = '0;
      dlen_d = '0;
    end else if (acc) begin
      for (int g = 0; g < UID_BYTES; g++) begin
        if (idx == CNT_W'(OFS_UID + g)) uid_d[8*g +: 8] = din;
      end
      for (int g = 0; g < DCRC_BYTES; g++) begin
        if (idx == CNT_W'(OFS_DCRC + g)) dcrc_d[8*g +: 8] = din;
      end
      if (idx == C_REV)    rev_d = din;
      if (idx == C_LEN_LO) dlen_d[7:0] = din;
      if (idx == C_LEN_HI) dlen_d[LEN_W-1:8] = din[LEN_W-9:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_exp   <= '0;
      uid      <= '0;
      dcrc_exp <= '0;
      rev      <= '0;
      dlen     <= '0;
    end else if (acc) begin
      id_exp   <= id_d;
      uid      <= uid_d;
      dcrc_exp <= dcrc_d;
      rev      <= rev_d;
      dlen     <= dlen_d;
    end
  end

  // R2: only the low bits of the upper length byte reach the length
  p_len_high_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && idx == C_LEN_HI) |=> (dlen[LEN_W-1:8] == $past(din[LEN_W-9:0])));

  // R1: a new image drops the previous image's fields
  p_start_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (uid == '0 && rev == '0 && dlen == '0));

endmodule

// File: rtl/desc_hdr_check.sv
module desc_hdr_check
  import desc_hdr_pkg::*;
#(
  parameter int LEN_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  input  logic             in_last,
  output logic             done,
  output logic             pass,
  output logic [2:0]       err_code,
  output logic [63:0]      uid,
  output logic             rev_warn,
  output logic [LEN_W:0]   img_size
);

  localparam int CNT_W = LEN_W + 1;
  localparam logic [CNT_W-1:0] C_ONE     = CNT_W'(1);
  localparam logic [CNT_W-1:0] C_MAX     = '1;
  localparam logic [CNT_W-1:0] C_ID_LO   = CNT_W'(OFS_UID);
  localparam logic [CNT_W-1:0] C_ID_HI   = CNT_W'(OFS_UID + UID_BYTES - 1);
  localparam logic [CNT_W-1:0] C_DSTART  = CNT_W'(DATA_START);
  localparam logic [CNT_W-1:0] C_LSEEN   = CNT_W'(LEN_SEEN);
  localparam logic [CNT_W-1:0] C_REVSEEN = CNT_W'(OFS_REV + 1);
  localparam logic [CNT_W-1:0] C_HDR     = CNT_W'(HDR_BYTES);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // byte position tracking
  logic             acc;
  logic             fresh_q, fresh_d;
  logic             done_q, done_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, idx;

  always_comb begin
    acc     = in_valid;
    idx     = fresh_q ? '0 : cnt_q;
    cnt_d   = cnt_q;
    fresh_d = fresh_q;
    done_d  = 1'b0;
    if (acc) begin
      cnt_d   = (idx == C_MAX) ? idx : idx + C_ONE;
      fresh_d = in_last;
      done_d  = in_last;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      fresh_q <= 1'b1;
      done_q  <= 1'b0;
      cnt_q   <= '0;
    end else begin
      done_q <= done_d;
      if (acc) begin
        fresh_q <= fresh_d;
        cnt_q   <= cnt_d;
      end
    end
  end

  // header fields
  logic [7:0]       id_exp;
  logic [31:0]      dcrc_exp;
  logic [7:0]       rev;
  logic [LEN_W-1:0] dlen;
  logic [CNT_W-1:0] total;

  hdr_fields #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_fields (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .acc      (acc),
    .idx      (idx),
    .din      (in_data),
    .id_exp   (id_exp),
    .uid      (uid),
    .dcrc_exp (dcrc_exp),
    .rev      (rev),
    .dlen     (dlen)
  );

  assign total = {1'b0, dlen} + C_DSTART;

  // checksum lanes
  logic        start;
  logic        id_en, data_en;
  logic [7:0]  crc8_q;
  logic [31:0] crc32_q;

  assign start   = acc && (idx == '0);
  assign id_en   = acc && (idx >= C_ID_LO) && (idx <= C_ID_HI);
  assign data_en = acc && (idx >= C_DSTART) && ((idx < C_LSEEN) || (idx < total));

  crc_lane #(.W(8), .POLY(8'h07), .INIT(8'hFF), .LSB_FIRST(1'b0)) u_id_crc (
    .clk   (clk),
    .rst_n (rst_int_n),
    .clr   (start),
    .en    (id_en),
    .din   (in_data),
    .crc_q (crc8_q)
  );

  crc_lane #(.W(32), .POLY(32'h82F6_3B78), .INIT(32'hFFFF_FFFF), .LSB_FIRST(1'b1)) u_data_crc (
    .clk   (clk),
    .rst_n (rst_int_n),
    .clr   (start),
    .en    (data_en),
    .din   (in_data),
    .crc_q (crc32_q)
  );

  // status decode in priority order
  hdr_err_e err;

  always_comb begin
    if (cnt_q < C_LSEEN)               err = ERR_SIZE;
    else if (total < C_HDR)            err = ERR_SMALL;
    else if (cnt_q != total)           err = ERR_SIZE;
    else if (crc8_q != id_exp)         err = ERR_IDCRC;
    else if (~crc32_q != dcrc_exp)     err = ERR_DATACRC;
    else                               err = ERR_NONE;
  end

  assign done     = done_q;
  assign err_code = err;
  assign pass     = done_q && (err == ERR_NONE);
  assign rev_warn = (cnt_q >= C_REVSEEN) && (rev > 8'd1);
  assign img_size = total;

  // R1: no byte, no movement
  p_idle_no_count_r1: assert property (@(posedge clk) disable iff (!rst_int_n)
    !in_valid |=> ($stable(cnt_q) && $stable(fresh_q)));

  // R4: the byte counter saturates instead of wrapping
  p_count_saturates_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (acc && !fresh_q && cnt_q == C_MAX) |=> (cnt_q == C_MAX));

  // R3: a passing image was at least a full header long
  p_pass_full_header_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    pass |-> (cnt_q >= C_HDR && total >= C_HDR));

  // R9: the strobe lasts one cycle unless another image ends
  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    (done && !(in_valid && in_last)) |=> !done);

endmodule

// File: tb/test_desc_hdr_check.sv
module test_desc_hdr_check;

  localparam int CLK_PERIOD = 10;
  localparam int FR_MAX     = 1200;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_last;
  logic [7:0]  in_data;
  logic        done, pass, rev_warn;
  logic [2:0]  err_code;
  logic [63:0] uid;
  logic [10:0] img_size;

  int ntest = 0;
  int nfail = 0;

  logic [7:0] fr [FR_MAX];
  int n;

  desc_hdr_check i_desc_hdr_check (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_data  (in_data),
    .in_last  (in_last),
    .done     (done),
    .pass     (pass),
    .err_code (err_code),
    .uid      (uid),
    .rev_warn (rev_warn),
    .img_size (img_size)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    ntest++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_crc8();
    logic [7:0] v = 8'hFF;
    for (int i = 1; i <= 8; i++) begin
      v ^= fr[i];
      for (int j = 0; j < 8; j++) v = v[7] ? ((v << 1) ^ 8'h07) : (v << 1);
    end
    return v;
  endfunction

  function automatic logic [31:0] ref_crc32c(int len);
    logic [31:0] v = 32'hFFFF_FFFF;
    for (int i = 13; i < 13 + len; i++) begin
      v ^= {24'h0, fr[i]};
      for (int j = 0; j < 8; j++) v = v[0] ? ((v >> 1) ^ 32'h82F6_3B78) : (v >> 1);
    end
    return ~v;
  endfunction

  function automatic int ref_err();
    int len, tot;
    if (n < 16) return 2;
    len = {fr[15][1:0], fr[14]};
    tot = len + 13;
    if (tot < 22) return 1;
    if (n != tot) return 2;
    if (ref_crc8() != fr[0]) return 3;
    if (ref_crc32c(len) != {fr[12], fr[11], fr[10], fr[9]}) return 4;
    return 0;
  endfunction

  // consistent image with correct checksums
  task automatic build(int len, int rev);
    logic [31:0] c;
    for (int i = 0; i < FR_MAX; i++) fr[i] = 8'($urandom);
    fr[13] = 8'(rev);
    fr[14] = len[7:0];
    fr[15] = {6'($urandom), len[9:8]};
    fr[0]  = ref_crc8();
    c      = ref_crc32c(len);
    fr[9]  = c[7:0];
    fr[10] = c[15:8];
    fr[11] = c[23:16];
    fr[12] = c[31:24];
    n = len + 13;
  endtask

  task automatic send();
    for (int i = 0; i < n; i++) begin
      if ($urandom_range(0, 3) == 0) begin
        in_valid = 1'b0;
        in_data  = 8'($urandom);
        in_last  = 1'($urandom);
        @(negedge clk);
      end
      in_valid = 1'b1;
      in_data  = fr[i];
      in_last  = (i == n - 1);
      @(negedge clk);
    end
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic run_frame();
    int e;
    string tag;
    e = ref_err();
    case (e)
      0: tag = "R6 clean image";
      1: tag = "R3 too small";
      2: tag = "R4 size mismatch";
      3: tag = "R5 id crc";
      default: tag = "R6 data crc";
    endcase
    send();
    chk("R9 done after last byte", 64'(done), 64'd1);
    chk({"R7 err_code ", tag}, 64'(err_code), 64'(e));
    chk("R9 pass matches err_code", 64'(pass), 64'(e == 0));
    if (n >= 16) begin
      chk("R2 uid little-endian", uid, {fr[8], fr[7], fr[6], fr[5], fr[4], fr[3], fr[2], fr[1]});
      chk("R2 img_size", 64'(img_size), 64'({fr[15][1:0], fr[14]} + 13));
    end
    if (n >= 14) chk("R8 rev_warn", 64'(rev_warn), 64'(fr[13] > 8'd1));
    @(negedge clk);
    chk("R9 done single cycle", 64'(done), 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", ntest, nfail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0; in_valid = 1'b0; in_last = 1'b0; in_data = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 reset done low", 64'(done), 64'd0);
    chk("R9 reset pass low", 64'(pass), 64'd0);

    // directed corner cases
    build(40, 0);   run_frame();                      // R6 clean
    build(40, 2);   run_frame();                      // R8 warn, still pass
    build(40, 1);   run_frame();                      // R8 no warn at 1
    build(9, 0);    run_frame();                      // R3 exact 22-byte boundary
    build(8, 0);    run_frame();                      // R3 21 bytes
    build(8, 0);    fr[3] ^= 8'h10; run_frame();      // R7 small beats id crc
    build(40, 0);   n = n + 1; run_frame();           // R4 one long
    build(40, 0);   n = n - 1; run_frame();           // R4 one short
    build(40, 0);   n = 10; run_frame();              // R4 under 16 bytes
    build(40, 0);   fr[3] ^= 8'h01; fr[20] ^= 8'h80; run_frame(); // R7 id beats data
    build(40, 0);   fr[20] ^= 8'h04; run_frame();     // R6 data byte
    build(40, 0);   fr[10] ^= 8'h40; run_frame();     // R6 stored crc
    build(40, 0);   fr[0] ^= 8'h01; run_frame();      // R5 stored crc
    build(40, 0);   fr[1] ^= 8'h20; n = n + 2; run_frame(); // R7 size beats id
    build(1023, 0); run_frame();                      // R2 maximum length

    // constrained random images
    for (int k = 0; k < 50; k++) begin
      int len, kind;
      len  = $urandom_range(9, 120);
      kind = $urandom_range(0, 5);
      build(len, $urandom_range(0, 1));
      case (kind)
        1: fr[$urandom_range(1, 8)] ^= 8'(1 << $urandom_range(0, 7));
        2: fr[$urandom_range(16, 12 + len)] ^= 8'(1 << $urandom_range(0, 7));
        3: n = n + $urandom_range(1, 5);
        4: n = n - $urandom_range(1, 6);
        5: fr[13] = 8'($urandom_range(2, 255));
        default: ;
      endcase
      if (kind == 5) begin
        logic [31:0] c;
        c = ref_crc32c(len);
        {fr[12], fr[11], fr[10], fr[9]} = c;
      end
      run_frame();
    end

    $display("  [TB] %0d tests run, %0d failed", ntest, nfail);
    $finish;
  end

endmodule